// File: doc/BRIEF.md
# Chip-Select Bus to Dual Wishbone Bridge

This block sits inside an FPGA and lets an external processor reach FPGA-side memories and peripherals through its asynchronous static-memory bus. The processor drives a bank of active-low chip selects, a bank offset, byte enables, write data and active-low read and write strobes. The bridge resolves the selected bank, rebuilds the full byte address of that bank's 64 MB window, and runs one Wishbone classic cycle on one of two master ports. Low-numbered banks go to a memory port and the top bank goes to a peripheral port. While that cycle runs, the bridge holds a wait request towards the processor.

The processor strobes are brought into the FPGA clock domain through a synchronizer of parameter depth. A cycle ends when the addressed slave acknowledges it, or when a parameter-length timeout expires. In both cases the wait request is released so that the processor can finish or abort its access. Read data is latched on the acknowledge and then zero-extended according to the byte lanes. The bridge keeps driving it while the processor holds its select and read strobe. The bridge also passes the FPGA clock and an inverted FPGA reset to the processor.

Top module: `csb_wb_bridge`

## Requirements
- R1: Selecting any of banks 0 to 4 runs the cycle on the memory port, and selecting bank 5 runs it on the peripheral port. CYC and STB of the other port stay low for the whole access.
- R2: The Wishbone word address is bits 31..2 of 0x4000_0000 + bank × 0x0400_0000 + offset, where the offset is the 26-bit `cpu_ofs_i`.
- R3: CYC and STB rise together on the selected port. WE is high when the write strobe is low and low when the read strobe is low.
- R4: SEL equals the inverse of `cpu_be_n_i`, where bit k low enables byte lane k (data bits 8k+7..8k). Write data, SEL and address are captured when the cycle starts and stay stable until it ends.
- R5: An ACK sampled while CYC is high ends the cycle, so CYC, STB and the wait request are low on the following clock. The wait request is high during every clock of the cycle.
- R6: Read data is formatted from the acknowledged word. SEL 0001, 0010, 0100 or 1000 returns that byte in bits 7..0. SEL 0011 or 1100 returns that halfword in bits 15..0. The upper bits are zero in both cases, and any other SEL returns the whole word.
- R7: With no ACK, CYC and STB stay high for exactly TIMEOUT clocks (default 16) and then drop together with the wait request. A read that ended this way returns zero.
- R8: After a cycle ends, no new cycle starts while any chip select remains low, so CYC stays low for at least one clock between cycles.
- R9: After a read ends, `cpu_rdata_oe_o` is high and `cpu_rdata_o` holds steady for as long as the select and read strobe stay low. It is low after they are released and low for writes.
- R10: When several chip selects are low at once, the lowest-numbered bank is served.
- R11: `cpu_rst_n_o` is the inverse of `rst_i` and `cpu_clk_o` follows `clk_i`.
- R12: During reset, CYC and STB of both ports, the wait request and the read-data enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | FPGA system clock |
| rst_i | input | 1 | Active-high synchronous reset |
| cpu_clk_o | output | 1 | Clock forwarded to the processor |
| cpu_rst_n_o | output | 1 | Active-low reset to the processor |
| cpu_cs_n_i | input | 6 | Active-low bank chip selects |
| cpu_ofs_i | input | 26 | Byte offset inside the bank window |
| cpu_be_n_i | input | 4 | Active-low byte lane enables |
| cpu_rd_n_i | input | 1 | Active-low read strobe |
| cpu_wr_n_i | input | 1 | Active-low write strobe |
| cpu_wdata_i | input | 32 | Write data from the processor |
| cpu_rdata_o | output | 32 | Formatted read data to the processor |
| cpu_rdata_oe_o | output | 1 | Read data drive enable |
| cpu_wait_o | output | 1 | Wait request, high while a cycle runs |
| mem_cyc_o | output | 1 | Memory port cycle |
| mem_stb_o | output | 1 | Memory port strobe |
| mem_we_o | output | 1 | Memory port write enable |
| mem_sel_o | output | 4 | Memory port byte selects |
| mem_adr_o | output | 30 | Memory port word address |
| mem_dat_o | output | 32 | Memory port write data |
| mem_dat_i | input | 32 | Memory port read data |
| mem_ack_i | input | 1 | Memory port acknowledge |
| io_cyc_o | output | 1 | Peripheral port cycle |
| io_stb_o | output | 1 | Peripheral port strobe |
| io_we_o | output | 1 | Peripheral port write enable |
| io_sel_o | output | 4 | Peripheral port byte selects |
| io_adr_o | output | 30 | Peripheral port word address |
| io_dat_o | output | 32 | Peripheral port write data |
| io_dat_i | input | 32 | Peripheral port read data |
| io_ack_i | input | 1 | Peripheral port acknowledge |

## Verification
A wrong bank decode or a wrong port-select register shows up on the first clock of CYC: either the wrong port rises or the address carries the wrong window. A fault in the timeout counter changes the number of clocks for which CYC stays high, which shows as soon as an access goes unacknowledged. A read-capture or lane-format fault appears on `cpu_rdata_o` on the clock after the cycle ends. A state machine that leaves its done state too early shows up as CYC rising again while the select is still held.

// File: rtl/csb_pkg.sv
package csb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_DONE = 2'd2
   } xfer_state_t;

   // zero-extended lane extraction for a 32-bit bus, keyed by byte selects
   function automatic logic [31:0] lane_fmt(input logic [31:0] word,
                                            input logic [3:0]  sel);
      logic [31:0] r;
      case (sel)
         4'b0001: r = {24'd0, word[7:0]};
         4'b0010: r = {24'd0, word[15:8]};
         4'b0100: r = {24'd0, word[23:16]};
         4'b1000: r = {24'd0, word[31:24]};
         4'b0011: r = {16'd0, word[15:0]};
         4'b1100: r = {16'd0, word[31:16]};
         default: r = word;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/csb_sync.sv
module csb_sync #(
   parameter int            WIDTH   = 8,
   parameter int            STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("csb_sync: WIDTH must be at least 1");
   end

   if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain_q;
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            chain_q <= {STAGES{RST_VAL}};
         end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
               chain_q[s] <= chain_q[s-1];
            end
         end
      end
      assign q_o = chain_q[STAGES-1];
   end

endmodule

// File: rtl/csb_bank_decode.sv
module csb_bank_decode #(
   parameter int NUM_CS  = 6,
   parameter int IO_BANK = 5,
   localparam int BANK_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic [NUM_CS-1:0] cs_n_i,
   output logic              any_o,
   output logic [BANK_W-1:0] bank_o,
   output logic              io_o
);

   if (IO_BANK >= NUM_CS) begin : g_bad_io
      $error("csb_bank_decode: IO_BANK must name an existing select");
   end

   // lowest-numbered active select wins: scan downward, last hit stays
   always_comb begin
      any_o  = 1'b0;
      bank_o = '0;
      for (int i = NUM_CS - 1; i >= 0; i--) begin
         if (!cs_n_i[i]) begin
            any_o  = 1'b1;
            bank_o = BANK_W'(i);
         end
      end
   end

   assign io_o = any_o && (bank_o >= BANK_W'(IO_BANK));

endmodule

// File: rtl/csb_xfer_ctrl.sv
module csb_xfer_ctrl
   import csb_pkg::*;
#(
   parameter int TIMEOUT = 16,
   localparam int CNT_W  = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic req_i,     // select and strobe seen low
   input  logic hold_i,    // any select still low
   input  logic ack_i,     // acknowledge from the chosen port
   output logic start_o,   // one-clock pulse: cycle begins
   output logic busy_o,    // Wishbone cycle in progress
   output logic done_o,    // cycle ended, waiting for select release
   output logic ack_end_o  // cycle ends by acknowledge this clock
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

   if (TIMEOUT < 2) begin : g_bad_to
      $error("csb_xfer_ctrl: TIMEOUT must be at least 2");
   end

   xfer_state_t state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               cnt_q <= '0;
               if (req_i) state_q <= ST_BUSY;
            end
            ST_BUSY: begin
               if (ack_i) begin
                  state_q <= ST_DONE;
                  cnt_q   <= '0;
               end else if (cnt_q == LAST) begin
                  state_q <= ST_DONE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_DONE: begin
               if (!hold_i) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign start_o   = (state_q == ST_IDLE) && req_i;
   assign busy_o    = (state_q == ST_BUSY);
   assign done_o    = (state_q == ST_DONE);
   assign ack_end_o = busy_o && ack_i;

   // R7: the counter never passes the timeout window
   assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      busy_o |-> (cnt_q <= LAST));

   // R7: last unacknowledged clock ends the cycle
   assert_timeout_end_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (busy_o && !ack_i && cnt_q == LAST) |=> done_o);

   // R5: acknowledge ends the cycle on the next clock
   assert_ack_end_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (busy_o && ack_i) |=> !busy_o);

   // R8: a finished cycle is never followed directly by another
   assert_gap_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |=> !busy_o);

   // R8: no restart while a select is still held
   assert_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_o && hold_i) |=> done_o);

endmodule

// File: rtl/csb_wb_lane.sv
module csb_wb_lane #(
   parameter int ADR_W  = 30,
   parameter int DATA_W = 32,
   localparam int SEL_W = DATA_W / 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   input  logic              we_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [ADR_W-1:0]  adr_i,
   input  logic [DATA_W-1:0] dat_i,
   output logic              cyc_o,
   output logic              stb_o,
   output logic              we_o,
   output logic [SEL_W-1:0]  sel_o,
   output logic [ADR_W-1:0]  adr_o,
   output logic [DATA_W-1:0] dat_o
);

   if (DATA_W % 8 != 0) begin : g_bad_dw
      $error("csb_wb_lane: DATA_W must be a whole number of bytes");
   end

   // an idle port drives all-zero so a slave never sees stale qualifiers
   assign cyc_o = en_i;
   assign stb_o = en_i;
   assign we_o  = en_i & we_i;
   assign sel_o = en_i ? sel_i : '0;
   assign adr_o = en_i ? adr_i : '0;
   assign dat_o = en_i ? dat_i : '0;

   // R4: qualifiers do not move while the port runs a cycle
   assert_stable_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && $past(en_i)) |-> ($stable(adr_o) && $stable(sel_o) &&
                                 $stable(dat_o) && $stable(we_o)));

endmodule

// File: rtl/csb_wb_bridge.sv
module csb_wb_bridge
   import csb_pkg::*;
#(
   parameter int          NUM_CS      = 6,
   parameter int          IO_BANK     = 5,
   parameter int          OFS_W       = 26,
   parameter int          DATA_W      = 32,
   parameter logic [31:0] BASE_ADDR   = 32'h4000_0000,
   parameter int          TIMEOUT     = 16,
   parameter int          SYNC_STAGES = 2,
   localparam int         SEL_W       = DATA_W / 8,
   localparam int         ADR_W       = 32 - $clog2(SEL_W)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   output logic              cpu_clk_o,
   output logic              cpu_rst_n_o,
   input  logic [NUM_CS-1:0] cpu_cs_n_i,
   input  logic [OFS_W-1:0]  cpu_ofs_i,
   input  logic [SEL_W-1:0]  cpu_be_n_i,
   input  logic              cpu_rd_n_i,
   input  logic              cpu_wr_n_i,
   input  logic [DATA_W-1:0] cpu_wdata_i,
   output logic [DATA_W-1:0] cpu_rdata_o,
   output logic              cpu_rdata_oe_o,
   output logic              cpu_wait_o,
   output logic              mem_cyc_o,
   output logic              mem_stb_o,
   output logic              mem_we_o,
   output logic [SEL_W-1:0]  mem_sel_o,
   output logic [ADR_W-1:0]  mem_adr_o,
   output logic [DATA_W-1:0] mem_dat_o,
   input  logic [DATA_W-1:0] mem_dat_i,
   input  logic              mem_ack_i,
   output logic              io_cyc_o,
   output logic              io_stb_o,
   output logic              io_we_o,
   output logic [SEL_W-1:0]  io_sel_o,
   output logic [ADR_W-1:0]  io_adr_o,
   output logic [DATA_W-1:0] io_dat_o,
   input  logic [DATA_W-1:0] io_dat_i,
   input  logic              io_ack_i
);

   localparam int BANK_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
   localparam int SYNC_W  = NUM_CS + 2;
   localparam int NPORTS  = 2;
   localparam int LSB_W   = $clog2(SEL_W);

   if (DATA_W != 32) begin : g_bad_dw
      $error("csb_wb_bridge: lane formatting is defined for a 32-bit bus");
   end
   if (OFS_W + BANK_W > 32) begin : g_bad_ofs
      $error("csb_wb_bridge: bank windows overflow the address space");
   end

   // clock and reset towards the processor (R11)
   assign cpu_clk_o   = clk_i;
   assign cpu_rst_n_o = ~rst_i;

   // ------------------------------------------------------------ strobes in
   logic [SYNC_W-1:0] sync_q;
   logic [NUM_CS-1:0] cs_n_s;
   logic              rd_n_s, wr_n_s;

   csb_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   ({cpu_rd_n_i, cpu_wr_n_i, cpu_cs_n_i}),
      .q_o   (sync_q)
   );
   assign cs_n_s = sync_q[NUM_CS-1:0];
   assign wr_n_s = sync_q[NUM_CS];
   assign rd_n_s = sync_q[NUM_CS+1];

   // ------------------------------------------------------------ decode
   logic              any_sel;
   logic [BANK_W-1:0] bank;
   logic              bank_io;

   csb_bank_decode #(.NUM_CS(NUM_CS), .IO_BANK(IO_BANK)) u_dec (
      .cs_n_i (cs_n_s),
      .any_o  (any_sel),
      .bank_o (bank),
      .io_o   (bank_io)
   );

   // ------------------------------------------------------------ control
   logic start, busy, done, ack_end, ack_mux;
   logic io_q;

   assign ack_mux = io_q ? io_ack_i : mem_ack_i;

   csb_xfer_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .req_i     (any_sel && (!rd_n_s || !wr_n_s)),
      .hold_i    (any_sel),
      .ack_i     (ack_mux),
      .start_o   (start),
      .busy_o    (busy),
      .done_o    (done),
      .ack_end_o (ack_end)
   );

   // ------------------------------------------------------------ capture
   logic [31:0]       byte_adr;
   logic [ADR_W-1:0]  adr_q;
   logic [SEL_W-1:0]  sel_q;
   logic [DATA_W-1:0] wdat_q;
   logic [DATA_W-1:0] rdat_q;
   logic              we_q;

   assign byte_adr = BASE_ADDR + (32'(bank) << OFS_W) + 32'(cpu_ofs_i);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         io_q   <= 1'b0;
         we_q   <= 1'b0;
         adr_q  <= '0;
         sel_q  <= '0;
         wdat_q <= '0;
         rdat_q <= '0;
      end else if (start) begin
         io_q   <= bank_io;
         we_q   <= !wr_n_s;
         adr_q  <= byte_adr[31:LSB_W];
         sel_q  <= ~cpu_be_n_i;
         wdat_q <= cpu_wdata_i;
         rdat_q <= '0;                  // stays zero on a timeout
      end else if (ack_end) begin
         rdat_q <= lane_fmt(io_q ? io_dat_i : mem_dat_i, sel_q);
      end
   end

   assign cpu_wait_o     = busy;
   assign cpu_rdata_o    = rdat_q;
   assign cpu_rdata_oe_o = done && !we_q && any_sel && !rd_n_s;

   // ------------------------------------------------------------ ports
   logic [NPORTS-1:0]             p_cyc, p_stb, p_we;
   logic [NPORTS-1:0][SEL_W-1:0]  p_sel;
   logic [NPORTS-1:0][ADR_W-1:0]  p_adr;
   logic [NPORTS-1:0][DATA_W-1:0] p_dat;

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      csb_wb_lane #(.ADR_W(ADR_W), .DATA_W(DATA_W)) u_lane (
         .clk_i (clk_i),
         .rst_i (rst_i),
         .en_i  (busy && (io_q == (p == 1))),
         .we_i  (we_q),
         .sel_i (sel_q),
         .adr_i (adr_q),
         .dat_i (wdat_q),
         .cyc_o (p_cyc[p]),
         .stb_o (p_stb[p]),
         .we_o  (p_we[p]),
         .sel_o (p_sel[p]),
         .adr_o (p_adr[p]),
         .dat_o (p_dat[p])
      );
   end

   assign mem_cyc_o = p_cyc[0];
   assign mem_stb_o = p_stb[0];
   assign mem_we_o  = p_we[0];
   assign mem_sel_o = p_sel[0];
   assign mem_adr_o = p_adr[0];
   assign mem_dat_o = p_dat[0];
   assign io_cyc_o  = p_cyc[1];
   assign io_stb_o  = p_stb[1];
   assign io_we_o   = p_we[1];
   assign io_sel_o  = p_sel[1];
   assign io_adr_o  = p_adr[1];
   assign io_dat_o  = p_dat[1];

   // R1: never both ports at once
   assert_one_port_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0({mem_cyc_o, io_cyc_o, mem_stb_o & ~mem_cyc_o, io_stb_o & ~io_cyc_o}));

   // R5: the wait request covers every clock of a port cycle
   assert_wait_cover_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (mem_cyc_o || io_cyc_o) |-> cpu_wait_o);

   // R9: read data is driven only outside a port cycle and holds steady
   assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      (cpu_rdata_oe_o && $past(cpu_rdata_oe_o)) |-> $stable(cpu_rdata_o));

   assert_rdata_idle_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      cpu_rdata_oe_o |-> !(mem_cyc_o || io_cyc_o));

   // R12: quiet outputs during reset
   assert_reset_quiet_R12: assert property (@(posedge clk_i)
      rst_i |=> (rst_i -> !(mem_cyc_o || io_cyc_o || cpu_wait_o || cpu_rdata_oe_o)));

endmodule

// File: tb/tb_csb_wb_bridge.sv
`timescale 1ns/1ps
module tb_csb_wb_bridge;

   localparam int TO   = 16;
   localparam int SYNC = 2;

   logic        clk = 1'b0;
   logic        rst_i;
   logic        cpu_clk_o, cpu_rst_n_o;
   logic [5:0]  cpu_cs_n_i;
   logic [25:0] cpu_ofs_i;
   logic [3:0]  cpu_be_n_i;
   logic        cpu_rd_n_i, cpu_wr_n_i;
   logic [31:0] cpu_wdata_i, cpu_rdata_o;
   logic        cpu_rdata_oe_o, cpu_wait_o;
   logic        mem_cyc_o, mem_stb_o, mem_we_o, mem_ack_i;
   logic [3:0]  mem_sel_o;
   logic [29:0] mem_adr_o;
   logic [31:0] mem_dat_o, mem_dat_i;
   logic        io_cyc_o, io_stb_o, io_we_o, io_ack_i;
   logic [3:0]  io_sel_o;
   logic [29:0] io_adr_o;
   logic [31:0] io_dat_o, io_dat_i;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   csb_wb_bridge dut (
      .clk_i(clk), .rst_i(rst_i), .cpu_clk_o(cpu_clk_o), .cpu_rst_n_o(cpu_rst_n_o),
      .cpu_cs_n_i(cpu_cs_n_i), .cpu_ofs_i(cpu_ofs_i), .cpu_be_n_i(cpu_be_n_i),
      .cpu_rd_n_i(cpu_rd_n_i), .cpu_wr_n_i(cpu_wr_n_i), .cpu_wdata_i(cpu_wdata_i),
      .cpu_rdata_o(cpu_rdata_o), .cpu_rdata_oe_o(cpu_rdata_oe_o), .cpu_wait_o(cpu_wait_o),
      .mem_cyc_o(mem_cyc_o), .mem_stb_o(mem_stb_o), .mem_we_o(mem_we_o),
      .mem_sel_o(mem_sel_o), .mem_adr_o(mem_adr_o), .mem_dat_o(mem_dat_o),
      .mem_dat_i(mem_dat_i), .mem_ack_i(mem_ack_i),
      .io_cyc_o(io_cyc_o), .io_stb_o(io_stb_o), .io_we_o(io_we_o),
      .io_sel_o(io_sel_o), .io_adr_o(io_adr_o), .io_dat_o(io_dat_o),
      .io_dat_i(io_dat_i), .io_ack_i(io_ack_i)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [29:0] exp_adr(input int bank, input logic [25:0] ofs);
      logic [31:0] f;
      f = 32'h4000_0000 + (32'(bank) << 26) + {6'd0, ofs};
      return f[31:2];
   endfunction

   function automatic logic [31:0] exp_fmt(input logic [31:0] d, input logic [3:0] be_n);
      logic [3:0] s;
      s = ~be_n;
      case (s)
         4'b0001: return {24'd0, d[7:0]};
         4'b0010: return {24'd0, d[15:8]};
         4'b0100: return {24'd0, d[23:16]};
         4'b1000: return {24'd0, d[31:24]};
         4'b0011: return {16'd0, d[15:0]};
         4'b1100: return {16'd0, d[31:16]};
         default: return d;
      endcase
   endfunction

   // one processor access; lat >= TO means the slave never acknowledges
   task automatic xfer(input logic [5:0] csn, input int bank, input logic [25:0] ofs,
                       input bit wr, input logic [3:0] ben, input logic [31:0] wd,
                       input int lat, input logic [31:0] rd, input int hold);
      bit io;
      int n;
      int cnt;
      int exp_cnt;
      logic [29:0] a0;
      logic [31:0] d0;
      logic [31:0] exp_rd;
      io = (bank == 5);
      @(negedge clk);
      cpu_cs_n_i = csn; cpu_ofs_i = ofs; cpu_be_n_i = ben;
      cpu_wr_n_i = !wr; cpu_rd_n_i = wr; cpu_wdata_i = wd;
      n = 0;
      while (!(mem_cyc_o || io_cyc_o) && n < 20) begin
         chk(!cpu_rdata_oe_o, "R9 no drive before cycle", 32'(cpu_rdata_oe_o), 0);
         @(negedge clk); n++;
      end
      chk(mem_cyc_o || io_cyc_o, "R3 cycle starts", 32'(n), 32'(SYNC + 1));
      chk(io ? (io_cyc_o && !mem_cyc_o) : (mem_cyc_o && !io_cyc_o), "R1 port choice",
          {30'd0, io_cyc_o, mem_cyc_o}, io ? 32'd2 : 32'd1);
      chk(io ? io_stb_o : mem_stb_o, "R3 stb with cyc", 0, 1);
      chk((io ? io_we_o : mem_we_o) == wr, "R3 we", 32'(io ? io_we_o : mem_we_o), 32'(wr));
      chk((io ? io_adr_o : mem_adr_o) == exp_adr(bank, ofs), "R2 R10 word address",
          32'(io ? io_adr_o : mem_adr_o), 32'(exp_adr(bank, ofs)));
      chk((io ? io_sel_o : mem_sel_o) == ~ben, "R4 sel", 32'(io ? io_sel_o : mem_sel_o),
          32'(~ben));
      if (wr) chk((io ? io_dat_o : mem_dat_o) == wd, "R4 write data",
                  io ? io_dat_o : mem_dat_o, wd);
      a0 = io ? io_adr_o : mem_adr_o;
      d0 = io ? io_dat_o : mem_dat_o;
      cnt = 0;
      while ((mem_cyc_o || io_cyc_o) && cnt < 100) begin
         cnt++;
         if (cnt > 1) begin
            if ((io ? io_adr_o : mem_adr_o) != a0 || (io ? io_dat_o : mem_dat_o) != d0)
               chk(0, "R4 stable during cycle", 32'(io ? io_adr_o : mem_adr_o), 32'(a0));
         end
         if (!cpu_wait_o) chk(0, "R5 wait high in cycle", 0, 1);
         if (io ? mem_cyc_o || mem_stb_o : io_cyc_o || io_stb_o)
            chk(0, "R1 other port quiet", 1, 0);
         if (lat < TO && cnt == lat + 1) begin
            if (io) io_ack_i = 1'b1; else mem_ack_i = 1'b1;
            io_dat_i = rd; mem_dat_i = rd;
         end
         @(negedge clk);
         io_ack_i = 1'b0; mem_ack_i = 1'b0;
      end
      exp_cnt = (lat < TO) ? lat + 1 : TO;
      chk(cnt == exp_cnt, (lat < TO) ? "R5 ack length" : "R7 timeout length",
          32'(cnt), 32'(exp_cnt));
      chk(!cpu_wait_o, (lat < TO) ? "R5 wait released" : "R7 wait released",
          32'(cpu_wait_o), 0);
      if (!wr) begin
         exp_rd = (lat < TO) ? exp_fmt(rd, ben) : 32'd0;
         chk(cpu_rdata_oe_o, "R9 drive after read", 32'(cpu_rdata_oe_o), 1);
         chk(cpu_rdata_o == exp_rd, (lat < TO) ? "R6 read format" : "R7 zero on timeout",
             cpu_rdata_o, exp_rd);
      end else begin
         chk(!cpu_rdata_oe_o, "R9 no drive on write", 32'(cpu_rdata_oe_o), 0);
      end
      for (int h = 0; h < hold; h++) begin
         @(negedge clk);
         if (mem_cyc_o || io_cyc_o) chk(0, "R8 no restart while held", 1, 0);
      end
      if (!wr) chk(cpu_rdata_oe_o && cpu_rdata_o == exp_rd, "R9 held read data",
                   cpu_rdata_o, exp_rd);
      @(negedge clk);
      cpu_cs_n_i = 6'h3F; cpu_rd_n_i = 1'b1; cpu_wr_n_i = 1'b1;
      repeat (SYNC + 2) @(negedge clk);
      chk(!cpu_rdata_oe_o, "R9 drive released", 32'(cpu_rdata_oe_o), 0);
      chk(!(mem_cyc_o || io_cyc_o), "R8 idle after release", 32'(mem_cyc_o | io_cyc_o), 0);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [3:0] be_tab [7];
      void'($urandom(32'd20240611));
      be_tab[0] = 4'b1110; be_tab[1] = 4'b1101; be_tab[2] = 4'b1011; be_tab[3] = 4'b0111;
      be_tab[4] = 4'b1100; be_tab[5] = 4'b0011; be_tab[6] = 4'b0000;
      rst_i = 1'b1; cpu_cs_n_i = 6'h3F; cpu_ofs_i = '0; cpu_be_n_i = 4'hF;
      cpu_rd_n_i = 1'b1; cpu_wr_n_i = 1'b1; cpu_wdata_i = '0;
      mem_dat_i = '0; io_dat_i = '0; mem_ack_i = 1'b0; io_ack_i = 1'b0;
      repeat (3) @(negedge clk);
      // R12 and R11 under reset
      chk(!(mem_cyc_o || mem_stb_o || io_cyc_o || io_stb_o), "R12 ports idle", 0, 0);
      chk(!cpu_wait_o && !cpu_rdata_oe_o, "R12 wait and drive low",
          {30'd0, cpu_wait_o, cpu_rdata_oe_o}, 0);
      chk(cpu_rst_n_o == 1'b0, "R11 reset out asserted", 32'(cpu_rst_n_o), 0);
      chk(cpu_clk_o == 1'b0, "R11 clock low phase", 32'(cpu_clk_o), 0);
      @(posedge clk); #1;
      chk(cpu_clk_o == 1'b1, "R11 clock high phase", 32'(cpu_clk_o), 1);
      @(negedge clk); rst_i = 1'b0;
      @(negedge clk);
      chk(cpu_rst_n_o == 1'b1, "R11 reset out released", 32'(cpu_rst_n_o), 1);

      // directed corners
      xfer(6'b111110, 0, 26'h000_0004, 0, 4'b0000, 0, 0, 32'hCAFE_F00D, 2);       // R6 word
      xfer(6'b011111, 5, 26'h3FF_FFFC, 1, 4'b0000, 32'h1234_5678, 3, 0, 0);     // R1 io write
      xfer(6'b011111, 5, 26'h000_0010, 0, 4'b1100, 0, 99, 32'hFFFF_FFFF, 1);    // R7 timeout
      xfer(6'b101111, 4, 26'h100_0000, 0, 4'b0111, 0, TO - 1, 32'hA1B2_C3D4, 0);// R6 byte, last ack
      xfer(6'b111011, 2, 26'h0AB_CDE0, 0, 4'b0011, 0, 1, 32'h8765_4321, 0);     // R6 upper half
      xfer(6'b000000, 0, 26'h000_0100, 1, 4'b1110, 32'h0000_00EE, 0, 0, 0);     // R10 all low
      xfer(6'b010101, 1, 26'h222_2220, 0, 4'b1101, 0, 2, 32'h0055_AA00, 0);     // R10 bank 1
      xfer(6'b110111, 3, 26'h000_0000, 1, 4'b0011, 32'hDEAD_BEEF, TO + 4, 0, 8);// R8 long hold

      // random traffic
      for (int it = 0; it < 60; it++) begin
         int bank;
         logic [5:0] hi;
         logic [5:0] csn;
         bank = int'($urandom % 6);
         hi = ($urandom % 4 == 0) ? (6'($urandom) & 6'(6'h3F << (bank + 1))) : 6'd0;
         csn = ~((6'd1 << bank) | hi);
         xfer(csn, bank, 26'($urandom) & 26'h3FF_FFFC, 1'($urandom), be_tab[$urandom % 7],
              $urandom, int'($urandom % 20), $urandom, int'($urandom % 3));
      end
      finish_run();
   end

endmodule